// File: doc/BRIEF.md
# Streaming Buffer Ring with Release Messages

This block sits on the device-to-host side of a streaming channel. User logic offers words on a valid/ready stream. The block writes each word into a ring of equally sized buffers through a simple write port, which stands in for a DMA path to host memory. When a buffer completes, the block hands it to the host by pushing a one-word message into a message FIFO and pulsing an interrupt. The host never polls a status register. Everything it needs to know, the buffer index and how many words that buffer holds, travels inside the message.

The host controls the ring through single register writes. It returns a buffer by writing that buffer's index. It can also ask the block to hand over the buffer currently being filled before that buffer is full. A handed-over buffer is never overwritten until it comes back. When the next buffer in the ring is still out, the block stalls the stream. A separate notification tells the host that data has appeared on a channel that was completely idle, so the host can wake a waiting reader before any buffer completes.

Top module: `dring_tx`

## Requirements
- R1: After reset every buffer is owned by the block and the fill pointer sits at buffer 0, word 0. The channel counts as empty, `s_ready` is 1, and `msg_push` and `irq` are 0.
- R2: Each accepted word is written in the cycle it is accepted, at address {buffer index, word offset}. Offsets rise by one per word inside the current buffer.
- R3: The word that fills the current buffer produces a release message carrying that buffer's index and a count of BUF_WORDS. Filling then moves on to the next buffer in the ring, modulo BUF_NUM. The message is pushed in the cycle after the filling word is accepted, provided the FIFO has room.
- R4: `irq` is high for exactly one cycle, the cycle after each message push.
- R5: A submit command (`reg_op`=1) given while the current buffer holds at least one word makes the block release that buffer, with its actual word count, once no word is being accepted. A submit given while the current buffer is empty, and with no word accepted in that cycle, is ignored.
- R6: A released buffer stays out of use until the host writes its index with `reg_op`=0. While the current buffer is out, `s_ready` is 0 and nothing is written. A return written in a cycle raises `s_ready` in that same cycle. A return naming a buffer that is not out, or an index of BUF_NUM or more, changes nothing.
- R7: The first word accepted while the channel is empty produces a nonempty message carrying the current buffer index and a count of 0. The channel counts as empty again only when every buffer is back and the current buffer holds no words. No other nonempty message is produced.
- R8: With NONEMPTY_EN=0 no nonempty message is ever produced. Release messages are unchanged.
- R9: A message that meets a full FIFO (`msg_full`=1) is held, unchanged, and is never dropped. While it is held, `s_ready` is 0. It is pushed in the first cycle in which `msg_full` is 0.
- R10: The message word has this layout: bits [31:28] opcode (1 = release, 2 = nonempty), bits [27:20] the CHAN_ID parameter, bits [19:12] the buffer index, bits [11:0] the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Stream word offered |
| s_data | input | DATA_W | Stream word (8, 16 or 32 bits) |
| s_ready | output | 1 | Stream word will be taken this cycle |
| reg_we | input | 1 | Host control write strobe |
| reg_op | input | 1 | 0 = return buffer `reg_idx`, 1 = submit partial buffer |
| reg_idx | input | 8 | Buffer index for a return |
| buf_we | output | 1 | Buffer memory write enable |
| buf_addr | output | log2(BUF_NUM)+log2(BUF_WORDS) | {buffer index, word offset} |
| buf_wdata | output | DATA_W | Word to write |
| msg_full | input | 1 | Message FIFO cannot take a word |
| msg_push | output | 1 | Push `msg_data` into the message FIFO |
| msg_data | output | 32 | Message word |
| irq | output | 1 | One-cycle interrupt pulse after each push |

## Verification
The bench lets the ring wrap until both buffers are out. It then checks that the stream stalls and that a return which arrives while a word is waiting lets that word in during the same cycle; a design that applied the return one cycle late would lose that cycle, and one that ignored ownership would overwrite data the host is still reading. It returns every buffer, offers a submit on an empty buffer, and sends one word. This shows that exactly one fresh nonempty message appears and that the stale submit does not release a one-word buffer; a design that armed the submit anyway would emit a spurious release. Finally it holds the message FIFO full across a buffer completion. A design that dropped or changed the blocked message, or kept taking words behind it, would show up as a missing or altered release and as extra buffer writes.

// File: rtl/dring_pkg.sv
// Shared definitions for the streaming buffer ring: message opcodes and
// the packing of the 32-bit message word.
package dring_pkg;

    typedef enum logic [3:0] {
        OP_RELEASE  = 4'd1,
        OP_NONEMPTY = 4'd2
    } dring_op_e;

    // Packs opcode, channel, buffer index and word count into one message.
    function automatic logic [31:0] pack_msg(input dring_op_e op,
                                             input logic [7:0] chan,
                                             input logic [7:0] idx,
                                             input logic [11:0] count);
        return {op, chan, idx, count};
    endfunction

endpackage

// File: rtl/dring_hold.sv
// Ownership flags for the buffer ring. One flag per buffer is set when the
// buffer is released to the host and cleared when the host returns it.
// A return is visible in the same cycle through held_eff.
// Assumes: at most one set and one return per cycle; return indices of
// BUF_NUM or more match no buffer.
module dring_hold #(
    parameter int BUF_NUM = 4,
    localparam int IDX_W = $clog2(BUF_NUM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               ret_en,
    input  logic [7:0]         ret_idx,
    output logic [BUF_NUM-1:0] held_q,
    output logic [BUF_NUM-1:0] held_eff,
    output logic               any_next
);
    logic [BUF_NUM-1:0] held_d;

    for (genvar i = 0; i < BUF_NUM; i++) begin : g_buf
        logic ret_hit;
        logic set_hit;
        assign ret_hit     = ret_en && (ret_idx == 8'(i));
        assign set_hit     = set_en && (set_idx == IDX_W'(i));
        assign held_eff[i] = held_q[i] && !ret_hit;
        assign held_d[i]   = held_eff[i] || set_hit;
    end

    assign any_next = |held_d;

    // Registers the ownership flags; reset hands every buffer to the block.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end
endmodule

// File: rtl/dring_fill.sv
// Fill engine: accepts stream words into the current buffer, decides when
// a buffer is released (full, or host submit), and raises one message
// event per cycle at most (release or nonempty).
// Assumes: BUF_WORDS >= 2, so a nonempty and a full release never coincide;
// slot_ok says the message stage can take an event this cycle.
module dring_fill
    import dring_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BUF_WORDS   = 16,
    parameter int BUF_NUM     = 4,
    parameter int CHAN_ID     = 1,
    parameter bit NONEMPTY_EN = 1'b1,
    localparam int IDX_W  = $clog2(BUF_NUM),
    localparam int OFS_W  = $clog2(BUF_WORDS),
    localparam int ADDR_W = IDX_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic [DATA_W-1:0]  s_data,
    output logic               s_ready,
    input  logic               sub_req,
    input  logic [BUF_NUM-1:0] held_eff,
    input  logic               any_next,
    input  logic               slot_ok,
    output logic               rel_en,
    output logic [IDX_W-1:0]   rel_idx,
    output logic               buf_we,
    output logic [ADDR_W-1:0]  buf_addr,
    output logic [DATA_W-1:0]  buf_wdata,
    output logic               ev_valid,
    output logic [31:0]        ev_msg
);
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [OFS_W-1:0] cnt_q, cnt_d;
    logic             sub_q, sub_d;
    logic             empty_q, empty_d;
    logic             accept, full_rel, part_rel, ne_ev;
    logic [11:0]      rel_cnt;

    // Stream handshake and buffer write.
    always_comb begin
        s_ready   = !held_eff[cur_q] && slot_ok;
        accept    = s_valid && s_ready;
        buf_we    = accept;
        buf_addr  = {cur_q, cnt_q};
        buf_wdata = s_data;
    end

    // Release and notification decisions.
    always_comb begin
        full_rel = accept && (cnt_q == OFS_W'(BUF_WORDS - 1));
        part_rel = sub_q && !accept && slot_ok && (cnt_q != '0);
        rel_en   = full_rel || part_rel;
        rel_idx  = cur_q;
        rel_cnt  = full_rel ? 12'(BUF_WORDS) : 12'(cnt_q);
        ne_ev    = NONEMPTY_EN && accept && empty_q;
        ev_valid = rel_en || ne_ev;
        ev_msg   = rel_en ? pack_msg(OP_RELEASE, 8'(CHAN_ID), 8'(cur_q), rel_cnt)
                          : pack_msg(OP_NONEMPTY, 8'(CHAN_ID), 8'(cur_q), 12'd0);
    end

    // Next-state for pointer, word count, submit request and empty flag.
    always_comb begin
        cur_d = rel_en ? cur_q + 1'b1 : cur_q;
        if (rel_en)      cnt_d = '0;
        else if (accept) cnt_d = cnt_q + 1'b1;
        else             cnt_d = cnt_q;
        if (rel_en)                                 sub_d = 1'b0;
        else if (sub_req && (cnt_q != '0 || accept)) sub_d = 1'b1;
        else                                        sub_d = sub_q;
        empty_d = accept ? 1'b0 : (empty_q || (!any_next && cnt_d == '0));
    end

    // Fill-state registers; reset points at buffer 0 with an empty channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            cnt_q   <= '0;
            sub_q   <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            cur_q   <= cur_d;
            cnt_q   <= cnt_d;
            sub_q   <= sub_d;
            empty_q <= empty_d;
        end
    end
endmodule

// File: rtl/dring_msgq.sv
// One-entry message stage in front of the external message FIFO. An event
// is captured and pushed as soon as the FIFO has room; while it waits it
// stays unchanged. Issues the interrupt pulse one cycle after each push.
// Assumes: the producer raises an event only when slot_ok is 1.
module dring_msgq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_valid,
    input  logic [31:0] ev_msg,
    input  logic        msg_full,
    output logic        slot_ok,
    output logic        pend_q,
    output logic        msg_push,
    output logic [31:0] msg_data,
    output logic        irq
);
    logic [31:0] pmsg_q;

    // Push when holding a message and the FIFO has room.
    always_comb begin
        msg_push = pend_q && !msg_full;
        msg_data = pmsg_q;
        slot_ok  = !pend_q || !msg_full;
    end

    // Holds the waiting message; a new event refills the slot being pushed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pmsg_q <= '0;
        end else if (ev_valid) begin
            pend_q <= 1'b1;
            pmsg_q <= ev_msg;
        end else if (msg_push) begin
            pend_q <= 1'b0;
        end
    end

    // Interrupt strobe following each push.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= msg_push;
    end
endmodule

// File: rtl/dring_tx.sv
// Streaming buffer ring, device-to-host direction. Fills a ring of
// BUF_NUM buffers of BUF_WORDS words each from a valid/ready stream,
// reports released buffers and the empty-to-nonempty event as messages,
// and takes buffer returns and submit commands from host register writes.
// Assumes: DATA_W is 8, 16 or 32; BUF_WORDS and BUF_NUM are powers of two,
// 2 <= BUF_WORDS <= 2048 and 2 <= BUF_NUM <= 256.
module dring_tx #(
    parameter int DATA_W      = 32,
    parameter int BUF_WORDS   = 16,
    parameter int BUF_NUM     = 4,
    parameter int CHAN_ID     = 1,
    parameter bit NONEMPTY_EN = 1'b1,
    localparam int IDX_W  = $clog2(BUF_NUM),
    localparam int OFS_W  = $clog2(BUF_WORDS),
    localparam int ADDR_W = IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    input  logic              reg_we,
    input  logic              reg_op,
    input  logic [7:0]        reg_idx,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic              msg_full,
    output logic              msg_push,
    output logic [31:0]       msg_data,
    output logic              irq
);
    logic [BUF_NUM-1:0] held_q, held_eff;
    logic               any_next, slot_ok, pend_q;
    logic               rel_en, ev_valid;
    logic [IDX_W-1:0]   rel_idx;
    logic [31:0]        ev_msg;

    dring_hold #(.BUF_NUM(BUF_NUM)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (rel_en),
        .set_idx  (rel_idx),
        .ret_en   (reg_we && !reg_op),
        .ret_idx  (reg_idx),
        .held_q   (held_q),
        .held_eff (held_eff),
        .any_next (any_next)
    );

    dring_fill #(
        .DATA_W      (DATA_W),
        .BUF_WORDS   (BUF_WORDS),
        .BUF_NUM     (BUF_NUM),
        .CHAN_ID     (CHAN_ID),
        .NONEMPTY_EN (NONEMPTY_EN)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .sub_req   (reg_we && reg_op),
        .held_eff  (held_eff),
        .any_next  (any_next),
        .slot_ok   (slot_ok),
        .rel_en    (rel_en),
        .rel_idx   (rel_idx),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata),
        .ev_valid  (ev_valid),
        .ev_msg    (ev_msg)
    );

    dring_msgq u_msgq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_msg   (ev_msg),
        .msg_full (msg_full),
        .slot_ok  (slot_ok),
        .pend_q   (pend_q),
        .msg_push (msg_push),
        .msg_data (msg_data),
        .irq      (irq)
    );
endmodule

// File: rtl/dring_tx_chk.sv
// Property checker for dring_tx, attached by bind. Observes ports plus the
// ownership flags and the message-slot occupancy.
module dring_tx_chk #(
    parameter int BUF_WORDS = 16,
    parameter int BUF_NUM   = 4,
    localparam int IDX_W  = $clog2(BUF_NUM),
    localparam int OFS_W  = $clog2(BUF_WORDS),
    localparam int ADDR_W = IDX_W + OFS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               buf_we,
    input logic [ADDR_W-1:0]  buf_addr,
    input logic               reg_we,
    input logic               reg_op,
    input logic [7:0]         reg_idx,
    input logic               msg_full,
    input logic               msg_push,
    input logic [31:0]        msg_data,
    input logic               irq,
    input logic [BUF_NUM-1:0] held_q,
    input logic               pend_q
);
    logic [IDX_W-1:0] widx;
    logic             ret_now;
    assign widx    = buf_addr[ADDR_W-1:OFS_W];
    assign ret_now = reg_we && !reg_op && (reg_idx == 8'(widx));

    // R6: never write into a buffer the host still owns.
    a_r6_no_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (!held_q[widx] || ret_now));

    // R9: push only into a FIFO with room.
    a_r9_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        msg_push |-> !msg_full);

    // R9: a blocked message stays and stays unchanged.
    a_r9_blocked_msg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && msg_full) |=> (pend_q && $stable(msg_data)));

    // R10: only the two defined opcodes leave the block.
    a_r10_opcode_known: assert property (@(posedge clk) disable iff (!rst_n)
        msg_push |-> (msg_data[31:28] == 4'd1 || msg_data[31:28] == 4'd2));

    // R3: a release carries between 1 and BUF_WORDS words.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && msg_data[31:28] == 4'd1) |->
        (msg_data[11:0] != 12'd0 && msg_data[11:0] <= 12'(BUF_WORDS)));

    // R7: a nonempty message carries a zero count.
    a_r7_nonempty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && msg_data[31:28] == 4'd2) |-> (msg_data[11:0] == 12'd0));

    // R4: each push is followed by the interrupt strobe.
    a_r4_irq_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        msg_push |=> irq);
endmodule

bind dring_tx dring_tx_chk #(.BUF_WORDS(BUF_WORDS), .BUF_NUM(BUF_NUM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .buf_we   (buf_we),
    .buf_addr (buf_addr),
    .reg_we   (reg_we),
    .reg_op   (reg_op),
    .reg_idx  (reg_idx),
    .msg_full (msg_full),
    .msg_push (msg_push),
    .msg_data (msg_data),
    .irq      (irq),
    .held_q   (held_q),
    .pend_q   (pend_q)
);

// File: tb/dring_tx_bench.sv
`timescale 1ns/1ps
// Directed bench for dring_tx: 16-bit words, two buffers of four words,
// channel 5. A second instance with nonempty messages disabled shares the
// stimulus.
module dring_tx_bench;
    localparam int DW = 16;
    localparam int BW = 4;
    localparam int BN = 2;
    localparam int CH = 5;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          reg_we = 1'b0;
    logic          reg_op = 1'b0;
    logic [7:0]    reg_idx = '0;
    logic          msg_full = 1'b0;
    logic          s_ready, buf_we, msg_push, irq;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_wdata;
    logic [31:0]   msg_data;
    logic          q_ready, q_we, q_push, q_irq;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_wdata;
    logic [31:0]   q_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dring_tx #(.DATA_W(DW), .BUF_WORDS(BW), .BUF_NUM(BN), .CHAN_ID(CH),
               .NONEMPTY_EN(1'b1)) u_dring_tx (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .reg_we(reg_we), .reg_op(reg_op), .reg_idx(reg_idx),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .msg_full(msg_full), .msg_push(msg_push), .msg_data(msg_data), .irq(irq));

    dring_tx #(.DATA_W(DW), .BUF_WORDS(BW), .BUF_NUM(BN), .CHAN_ID(CH),
               .NONEMPTY_EN(1'b0)) u_dring_tx_quiet (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(q_ready), .reg_we(reg_we), .reg_op(reg_op), .reg_idx(reg_idx),
        .buf_we(q_we), .buf_addr(q_addr), .buf_wdata(q_wdata),
        .msg_full(msg_full), .msg_push(q_push), .msg_data(q_data), .irq(q_irq));

    // Host-side models: buffer memory, message FIFOs, event counters.
    logic [DW-1:0] mem [8];
    logic [31:0]   mq [16];
    logic [31:0]   qq [16];
    int mn = 0, qn = 0, irqn = 0, wn = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (buf_we) begin mem[buf_addr] = buf_wdata; wn++; end
            if (msg_push && mn < 16) begin mq[mn] = msg_data; mn++; end
            if (q_push && qn < 16) begin qq[qn] = q_data; qn++; end
            if (irq) irqn++;
        end
    end

    function automatic logic [31:0] msg(input int op, input int idx, input int n);
        return {4'(op), 8'(CH), 8'(idx), 12'(n)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [DW-1:0] d);
        s_valid = 1'b1;
        s_data  = d;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic host_write(input logic op, input logic [7:0] idx);
        reg_we = 1'b1; reg_op = op; reg_idx = idx;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // R1: state right after reset.
    task automatic t_reset;
        chk(s_ready == 1'b1, "R1 ready", 32'(s_ready), 1);
        chk(msg_push == 1'b0 && irq == 1'b0, "R1 quiet", {msg_push, irq}, 0);
        chk(buf_addr == '0, "R1 start address", 32'(buf_addr), 0);
    endtask

    // R2, R3, R4, R7, R10: fill buffer 0 completely.
    task automatic t_fill_full;
        for (int i = 0; i < BW; i++) send_word(16'hA000 + 16'(i));
        chk(msg_push == 1'b1, "R3 push cycle after fill", 32'(msg_push), 1);
        chk(msg_data == msg(1, 0, BW), "R3 R10 release word", msg_data, msg(1, 0, BW));
        @(negedge clk);
        chk(irq == 1'b1, "R4 irq high", 32'(irq), 1);
        @(negedge clk);
        chk(irq == 1'b0, "R4 irq one cycle", 32'(irq), 0);
        chk(mq[0] == msg(2, 0, 0), "R7 R10 nonempty word", mq[0], msg(2, 0, 0));
    endtask

    // R5: partial buffer 1 submitted on host command.
    task automatic t_submit;
        send_word(16'hB000);
        send_word(16'hB001);
        host_write(1'b1, 8'd0);
        @(negedge clk);
        chk(msg_push == 1'b1 && msg_data == msg(1, 1, 2), "R5 partial release",
            msg_data, msg(1, 1, 2));
        @(negedge clk);
    endtask

    // R6: stall with both buffers out, invalid returns, same-cycle return.
    task automatic t_stall;
        int w0;
        w0 = wn;
        chk(s_ready == 1'b0, "R6 stall when held", 32'(s_ready), 0);
        s_valid = 1'b1; s_data = 16'hC000;
        repeat (3) @(negedge clk);
        chk(wn == w0, "R6 no write while held", wn, w0);
        reg_we = 1'b1; reg_op = 1'b0; reg_idx = 8'd3; #1;
        chk(s_ready == 1'b0, "R6 out-of-range return ignored", 32'(s_ready), 0);
        @(negedge clk); reg_idx = 8'd1; #1;
        chk(s_ready == 1'b0, "R6 other buffer return", 32'(s_ready), 0);
        @(negedge clk); reg_idx = 8'd0; #1;
        chk(s_ready == 1'b1, "R6 return frees same cycle", 32'(s_ready), 1);
        @(negedge clk);
        reg_we = 1'b0; s_valid = 1'b0;
        chk(wn == w0 + 1, "R6 word taken on return", wn, w0 + 1);
        repeat (2) @(negedge clk);
        chk(mn == 3, "R7 no repeat nonempty", mn, 3);
        host_write(1'b1, 8'd0);
        @(negedge clk);
        chk(msg_push == 1'b1 && msg_data == msg(1, 0, 1), "R5 one-word release",
            msg_data, msg(1, 0, 1));
        @(negedge clk);
        host_write(1'b0, 8'd0);
    endtask

    // R5, R7: submit on an empty buffer is ignored; fresh nonempty after drain.
    task automatic t_rearm;
        host_write(1'b1, 8'd0);
        repeat (3) @(negedge clk);
        chk(mn == 4, "R5 empty submit ignored", mn, 4);
        send_word(16'hD000);
        chk(msg_push == 1'b1 && msg_data == msg(2, 1, 0), "R7 nonempty after drain",
            msg_data, msg(2, 1, 0));
        repeat (4) @(negedge clk);
        chk(mn == 5, "R5 stale submit not armed", mn, 5);
    endtask

    // R9: message held while the FIFO is full.
    task automatic t_full_fifo;
        msg_full = 1'b1;
        for (int i = 1; i < BW; i++) send_word(16'hD000 + 16'(i));
        for (int i = 0; i < 3; i++) begin
            chk(msg_push == 1'b0 && s_ready == 1'b0, "R9 held and stalled",
                {msg_push, s_ready}, 0);
            @(negedge clk);
        end
        msg_full = 1'b0; #1;
        chk(msg_push == 1'b1 && msg_data == msg(1, 1, BW), "R9 pushed when room",
            msg_data, msg(1, 1, BW));
        repeat (3) @(negedge clk);
        chk(mn == 6, "R9 not dropped or duplicated", mn, 6);
    endtask

    // End-of-run content checks across both instances.
    task automatic t_final;
        logic [DW-1:0] exp_mem [8];
        exp_mem = '{16'hC000, 16'hA001, 16'hA002, 16'hA003,
                    16'hD000, 16'hD001, 16'hD002, 16'hD003};
        for (int i = 0; i < 8; i++)
            chk(mem[i] == exp_mem[i], "R2 buffer contents", 32'(mem[i]), 32'(exp_mem[i]));
        chk(wn == 11, "R2 write count", wn, 11);
        chk(irqn == 6, "R4 irq count", irqn, 6);
        chk(mq[1] == msg(1, 0, BW), "R3 first release kept", mq[1], msg(1, 0, BW));
        chk(qn == 4, "R8 quiet message count", qn, 4);
        chk(qq[0] == mq[1] && qq[1] == mq[2] && qq[2] == mq[3] && qq[3] == mq[5],
            "R8 quiet releases match", qq[3], mq[5]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_full();
        t_submit();
        t_stall();
        t_rearm();
        t_full_fifo();
        t_final();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule